// File: doc/BRIEF.md
# Associative Translation Cache with Pinned Entries

This block is a small fully associative cache of address translations. It is given a virtual address, compares the page number part against every valid entry in the same cycle, and on a match returns a physical address. That physical address is the stored frame number joined to the page offset, which passes through unchanged. The lookup path is purely combinational, so the result is ready in the cycle the address is presented.

When a lookup misses, an outside agent walks the page table and returns the result on a one-cycle refill port. The refill carries the page number, the frame number and a pin flag. Placement follows a fixed order:

- A page number that is already cached is rewritten where it sits.
- Otherwise the lowest free slot is used.
- Otherwise a round-robin pointer picks the next slot that is not pinned.

Pinned entries are meant for translations that must always stay resident, such as kernel pages. Neither replacement nor a flush can remove them. If every slot is pinned, the refill is dropped and a failure pulse is raised.

Top module: `assoc_tlb`

## Requirements
- R1: A lookup whose page number matches a valid entry raises `lk_hit_o` in the same cycle. `lk_paddr_o` then equals {stored frame, address offset}, where the offset is the low OFF_W bits of `lk_vaddr_i`.
- R2: A lookup that matches no valid entry drives `lk_hit_o` low and `lk_paddr_o` to zero.
- R3: A refill whose page number is already cached replaces that entry's frame and pin flag. No second copy is made and no other entry is disturbed.
- R4: A refill of an uncached page goes into the lowest-numbered free slot whenever one exists. No valid entry is evicted while a slot is free.
- R5: When all slots are valid, the victim is the first unpinned slot at or after the round-robin pointer, in rising order with wrap-around. The pointer then moves to the slot after the victim. The pointer is 0 after reset.
- R6: A pinned entry is never chosen as a replacement victim.
- R7: `flush_i` invalidates every unpinned entry within one clock edge. Pinned entries survive the flush.
- R8: When every slot is valid and pinned, a refill of an uncached page changes nothing. `refill_fail_o` is high for exactly the one cycle after that clock edge.
- R9: A refill presented in the same cycle as `flush_i` is discarded: it is not stored and does not raise `refill_fail_o`.
- R10: After reset all entries are invalid and `refill_fail_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_vaddr_i | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_paddr_o | output | PFN_W+OFF_W | Translated physical address, zero on a miss |
| refill_valid_i | input | 1 | Refill request this cycle |
| refill_vpn_i | input | VPN_W | Page number to insert |
| refill_pfn_i | input | PFN_W | Frame number to insert |
| refill_wired_i | input | 1 | Pin the inserted entry |
| flush_i | input | 1 | Invalidate all unpinned entries |
| refill_fail_o | output | 1 | Previous refill was dropped because every slot is pinned |

## Verification
The bench refills a page that is already cached while the table is full. A design that inserted a duplicate would evict an innocent entry, and that entry's lookup would then miss. Eviction is walked across a pinned slot and around the wrap of the pointer. A design that ignored the pin flag, or restarted the pointer at slot 0, would lose the wrong page and the lookups that follow would show it. After a flush the table is refilled and then overfilled, which exposes a wrong free-slot order through the page that gets evicted. A table made entirely of pinned entries must reject a refill with a single-cycle failure pulse. A refill that coincides with a flush must leave no trace.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    VIC_NONE   = 2'd0,
    VIC_UPDATE = 2'd1,
    VIC_FREE   = 2'd2,
    VIC_EVICT  = 2'd3
  } victim_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int KEY_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][KEY_W-1:0] keys_i,
  input  logic [N-1:0]            valid_i,
  input  logic [KEY_W-1:0]        key_i,
  output logic [N-1:0]            hit_vec_o,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        hit_idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec_o[i] = valid_i[i] && (keys_i[i] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0]      wired_i,
  input  logic              upd_hit_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              req_i,
  output logic [IDX_W-1:0]  idx_o,
  output victim_kind_e      kind_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx, rr_idx;
  logic             free_any, rr_any;

  // lowest free slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // first unpinned slot at or after the pointer, with wrap
  always_comb begin
    rr_any = 1'b0;
    rr_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!rr_any && !wired_i[j]) begin
        rr_any = 1'b1;
        rr_idx = IDX_W'(j);
      end
    end
  end

  always_comb begin
    if (upd_hit_i) begin
      kind_o = VIC_UPDATE;
      idx_o  = upd_idx_i;
    end else if (free_any) begin
      kind_o = VIC_FREE;
      idx_o  = free_idx;
    end else if (rr_any) begin
      kind_o = VIC_EVICT;
      idx_o  = rr_idx;
    end else begin
      kind_o = VIC_NONE;
      idx_o  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (req_i && kind_o == VIC_EVICT) begin
      ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
    end
  end

  assert_free_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_o == VIC_EVICT) |-> (&valid_i));

  assert_victim_not_wired_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_o == VIC_EVICT) |-> !wired_i[idx_o]);
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  input  logic             refill_valid_i,
  input  logic [VPN_W-1:0] refill_vpn_i,
  input  logic [PFN_W-1:0] refill_pfn_i,
  input  logic             refill_wired_i,
  input  logic             flush_i,
  output logic             refill_fail_o
);
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0]            valid_q, wired_q;
  logic                          fail_q;

  logic [ENTRIES-1:0] lk_vec, rf_vec;
  logic               lk_hit, rf_hit;
  logic [IDX_W-1:0]   lk_idx, rf_idx, vic_idx;
  victim_kind_e       vic_kind;
  logic               accept;

  assign accept = refill_valid_i && !flush_i;

  tlb_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
    .keys_i    (vpn_q),
    .valid_i   (valid_q),
    .key_i     (lk_vaddr_i[VA_W-1:OFF_W]),
    .hit_vec_o (lk_vec),
    .hit_o     (lk_hit),
    .hit_idx_o (lk_idx)
  );

  tlb_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_rf_match (
    .keys_i    (vpn_q),
    .valid_i   (valid_q),
    .key_i     (refill_vpn_i),
    .hit_vec_o (rf_vec),
    .hit_o     (rf_hit),
    .hit_idx_o (rf_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_q),
    .wired_i   (wired_q),
    .upd_hit_i (rf_hit),
    .upd_idx_i (rf_idx),
    .req_i     (accept),
    .idx_o     (vic_idx),
    .kind_o    (vic_kind)
  );

  assign lk_hit_o      = lk_hit;
  assign lk_paddr_o    = lk_hit ? {pfn_q[lk_idx], lk_vaddr_i[OFF_W-1:0]} : '0;
  assign refill_fail_o = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q   <= '0;
      pfn_q   <= '0;
      valid_q <= '0;
      wired_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= accept && (vic_kind == VIC_NONE);
      if (flush_i) begin
        valid_q <= valid_q & wired_q;
      end else if (accept && vic_kind != VIC_NONE) begin
        vpn_q[vic_idx]   <= refill_vpn_i;
        pfn_q[vic_idx]   <= refill_pfn_i;
        wired_q[vic_idx] <= refill_wired_i;
        valid_q[vic_idx] <= 1'b1;
      end
    end
  end

  assert_no_dup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec) && $onehot0(rf_vec));

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((valid_q & ~wired_q) == '0));

  assert_fail_all_wired_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_fail_o |-> $past(&(valid_q & wired_q)));

  assert_flush_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && refill_valid_i) |=> !refill_fail_o);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_wired_chk
    assert_wired_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[i] && wired_q[i] && !(accept && rf_hit && rf_idx == IDX_W'(i)))
      |=> (valid_q[i] && vpn_q[i] == $past(vpn_q[i])));
  end
endmodule

// File: tb/assoc_tlb_tb_top.sv
module assoc_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int VPN_W = 20;
  localparam int PFN_W = 16;
  localparam int OFF_W = 12;

  localparam logic [1:0] OP_RF = 2'd0, OP_LK = 2'd1, OP_FL = 2'd2;
  localparam int NVEC = 31;
  // {op, vpn, pfn (expected for lookups), wired (expected hit for lookups), req}
  localparam logic [22:0] VEC [NVEC] = '{
    {OP_RF, 8'h01, 8'h11, 1'b0, 4'd1},
    {OP_RF, 8'h02, 8'h22, 1'b1, 4'd1},
    {OP_RF, 8'h03, 8'h33, 1'b0, 4'd1},
    {OP_RF, 8'h04, 8'h44, 1'b0, 4'd1},
    {OP_LK, 8'h01, 8'h11, 1'b1, 4'd1},  // R1
    {OP_LK, 8'h04, 8'h44, 1'b1, 4'd1},  // R1
    {OP_LK, 8'h09, 8'h00, 1'b0, 4'd2},  // R2
    {OP_RF, 8'h03, 8'h35, 1'b0, 4'd3},
    {OP_LK, 8'h03, 8'h35, 1'b1, 4'd3},  // R3 updated frame
    {OP_LK, 8'h01, 8'h11, 1'b1, 4'd3},  // R3 nothing evicted
    {OP_RF, 8'h05, 8'h55, 1'b0, 4'd5},
    {OP_LK, 8'h01, 8'h00, 1'b0, 4'd5},  // R5 slot0 evicted
    {OP_LK, 8'h05, 8'h55, 1'b1, 4'd5},
    {OP_RF, 8'h06, 8'h66, 1'b0, 4'd6},
    {OP_LK, 8'h02, 8'h22, 1'b1, 4'd6},  // R6 pinned slot skipped
    {OP_LK, 8'h03, 8'h00, 1'b0, 4'd5},  // R5 slot2 evicted
    {OP_RF, 8'h07, 8'h77, 1'b0, 4'd5},
    {OP_LK, 8'h04, 8'h00, 1'b0, 4'd5},  // R5 slot3 evicted
    {OP_LK, 8'h06, 8'h66, 1'b1, 4'd5},
    {OP_FL, 8'h00, 8'h00, 1'b0, 4'd7},
    {OP_LK, 8'h02, 8'h22, 1'b1, 4'd7},  // R7 pinned survives
    {OP_LK, 8'h05, 8'h00, 1'b0, 4'd7},  // R7
    {OP_LK, 8'h07, 8'h00, 1'b0, 4'd7},  // R7
    {OP_RF, 8'h08, 8'h88, 1'b0, 4'd4},
    {OP_RF, 8'h09, 8'h99, 1'b0, 4'd4},
    {OP_RF, 8'h0A, 8'hAA, 1'b0, 4'd4},
    {OP_RF, 8'h0B, 8'hBB, 1'b0, 4'd5},  // pointer wrapped to 0
    {OP_LK, 8'h08, 8'h00, 1'b0, 4'd4},  // R4 vpn8 sat in slot0
    {OP_LK, 8'h09, 8'h99, 1'b1, 4'd4},  // R4
    {OP_LK, 8'h0A, 8'hAA, 1'b1, 4'd4},
    {OP_LK, 8'h0B, 8'hBB, 1'b1, 4'd5}
  };

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [VPN_W+OFF_W-1:0]  lk_vaddr = '0;
  logic                    lk_hit;
  logic [PFN_W+OFF_W-1:0]  lk_paddr;
  logic                    refill_valid = 1'b0;
  logic [VPN_W-1:0]        refill_vpn = '0;
  logic [PFN_W-1:0]        refill_pfn = '0;
  logic                    refill_wired = 1'b0;
  logic                    flush = 1'b0;
  logic                    refill_fail;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assoc_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .lk_vaddr_i     (lk_vaddr),
    .lk_hit_o       (lk_hit),
    .lk_paddr_o     (lk_paddr),
    .refill_valid_i (refill_valid),
    .refill_vpn_i   (refill_vpn),
    .refill_pfn_i   (refill_pfn),
    .refill_wired_i (refill_wired),
    .flush_i        (flush),
    .refill_fail_o  (refill_fail)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [7:0] vpn, input logic [7:0] pfn,
                        input logic hit);
    logic [OFF_W-1:0] off;
    logic [PFN_W+OFF_W-1:0] exp_pa;
    off = {vpn, 4'h5};
    @(negedge clk);
    lk_vaddr = {12'h0, vpn, off};
    #1;
    exp_pa = hit ? {8'h00, pfn, off} : '0;
    check(req, 64'(lk_hit), 64'(hit));
    check(req, 64'(lk_paddr), 64'(exp_pa));
  endtask

  task automatic drive(input logic rv, input logic [7:0] vpn, input logic [7:0] pfn,
                       input logic w, input logic fl);
    @(negedge clk);
    refill_valid = rv;
    refill_vpn   = {12'h0, vpn};
    refill_pfn   = {8'h00, pfn};
    refill_wired = w;
    flush        = fl;
    @(negedge clk);
    refill_valid = 1'b0;
    flush        = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    check("R10 fail low", 64'(refill_fail), 64'd0);
    lookup("R10 empty", 8'h01, 8'h00, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      string req;
      op  = VEC[v][22:21];
      req = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
      case (op)
        OP_RF: begin
          drive(1'b1, VEC[v][20:13], VEC[v][12:5], VEC[v][4], 1'b0);
          check(req, 64'(refill_fail), 64'd0);
        end
        OP_FL: drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        default: lookup(req, VEC[v][20:13], VEC[v][12:5], VEC[v][4]);
      endcase
    end

    // R9 refill alongside flush is discarded
    drive(1'b1, 8'h40, 8'h44, 1'b0, 1'b1);
    check("R9 no fail", 64'(refill_fail), 64'd0);
    lookup("R9 not stored", 8'h40, 8'h00, 1'b0);
    lookup("R9 flush done", 8'h09, 8'h00, 1'b0);
    lookup("R7 pinned kept", 8'h02, 8'h22, 1'b1);

    // R8 table fully pinned
    drive(1'b1, 8'h20, 8'hA0, 1'b1, 1'b0);
    drive(1'b1, 8'h21, 8'hA1, 1'b1, 1'b0);
    drive(1'b1, 8'h22, 8'hA2, 1'b1, 1'b0);
    check("R8 fill ok", 64'(refill_fail), 64'd0);
    drive(1'b1, 8'h30, 8'hB0, 1'b0, 1'b0);
    check("R8 fail pulse", 64'(refill_fail), 64'd1);
    #1;
    lookup("R8 dropped", 8'h30, 8'h00, 1'b0);
    check("R8 pulse one cycle", 64'(refill_fail), 64'd0);
    lookup("R8 pinned intact", 8'h20, 8'hA0, 1'b1);
    lookup("R6 pinned intact", 8'h02, 8'h22, 1'b1);
    drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    lookup("R7 flush keeps pinned", 8'h22, 8'hA2, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule